// File: doc/BRIEF.md
# Video DAC Level Code Generator

This block is the digital front end of a composite video DAC. On each falling clock edge it samples an 8-bit unsigned pixel value and five active-low controls: blank, sync, reference-white, overbright and straight-DAC. It then produces one unsigned level code, counted in DAC LSB units, for a current-steering converter downstream.

The code is the effective pixel value plus a set of pedestals. Blank forces the pixel value to zero and takes precedence over reference-white and overbright. Sync acts on its own pedestal and does not change any other control. Straight-DAC mode removes all pedestals, so the code equals the effective pixel value. When no control is asserted, the block is in graphics mode and adds both the black and the blank pedestals. The output register updates one clock after the sample stage, so the pipeline has a fixed two-stage delay.

Top module: `vdac_level_gen`

## Requirements
- R1: Inputs are captured on a falling clock edge, and the level code for them appears at the output on the next falling edge. Inputs that are stable from one rising edge are visible at the output from the second rising edge after it, and are not visible at the first.
- R2: With all controls high, the level code is pixel + 21 (black pedestal) + 111 (blank pedestal). Pixel bit 0 is the LSB.
- R3: blankN low forces the effective pixel to 0, removes the 21 black pedestal and suppresses the effects of refWhiteN and overBrtN.
- R4: syncN low removes the 111 blank pedestal and changes no other term.
- R5: refWhiteN low forces the effective pixel to 255, unless blankN is low.
- R6: overBrtN low adds a 27 LSB overbright pedestal, unless blankN is low or straightN is low.
- R7: straightN low disables the black, blank and overbright pedestals, so the code equals the effective pixel (0 to 255). Blank and reference-white still force 0 and 255.
- R8: A synchronous active-high rst, sampled on the falling edge, clears both stages. The output then reads 132 (pixel 0 with all controls inactive). The 9-bit code reaches at most 414.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| pixIn | input | 8 | Unsigned pixel value |
| blankN | input | 1 | Blank control, active low |
| syncN | input | 1 | Sync control, active low |
| refWhiteN | input | 1 | Reference-white control, active low |
| overBrtN | input | 1 | Overbright control, active low |
| straightN | input | 1 | Straight-DAC control, active low |
| levelOut | output | 9 | Level code in LSB units |

## Verification
The bench applies all 32 combinations of the controls with pixel values 0, 1, 128 and 255. Pixel 0 against 255 separates a forced value from a passed-through one. Pixel 1 exposes a dropped bit 0, and pixel 128 exposes a swapped bit. Random pixel and control mixes then test how the pedestals add together under blank, sync and overbright. A back-to-back pair of vectors checks that the output is still old after one rising edge and new after two, which separates the correct delay from a one-stage or three-stage pipeline.

// File: rtl/vdac_pkg.sv
package vdac_pkg;
  typedef struct packed {
    logic forceZero;
    logic forceFull;
    logic addBlack;
    logic addBlank;
    logic addOver;
  } levelStrobes_t;
endpackage

// File: rtl/vdac_ctrl.sv
module vdac_ctrl
  import vdac_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          blankN,
  input  logic          syncN,
  input  logic          refWhiteN,
  input  logic          overBrtN,
  input  logic          straightN,
  output levelStrobes_t strobes
);
  logic blankQ, syncQ, whiteQ, overQ, straightQ;

  always_ff @(negedge clk) begin
    if (rst) begin
      blankQ    <= 1'b1;
      syncQ     <= 1'b1;
      whiteQ    <= 1'b1;
      overQ     <= 1'b1;
      straightQ <= 1'b1;
    end else begin
      blankQ    <= blankN;
      syncQ     <= syncN;
      whiteQ    <= refWhiteN;
      overQ     <= overBrtN;
      straightQ <= straightN;
    end
  end

  always_comb begin
    strobes.forceZero = ~blankQ;
    strobes.forceFull = blankQ & ~whiteQ;
    strobes.addBlack  = straightQ & blankQ;
    strobes.addBlank  = straightQ & syncQ;
    strobes.addOver   = straightQ & blankQ & ~overQ;
  end
endmodule

// File: rtl/vdac_datapath.sv
module vdac_datapath
  import vdac_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BLACK_PED = 21,
  parameter int BLANK_PED = 111,
  parameter int OVER_PED  = 27,
  parameter int LEVEL_W   = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  pixIn,
  input  levelStrobes_t      strobes,
  output logic [LEVEL_W-1:0] levelOut
);
  localparam logic [LEVEL_W-1:0] BLACK_L = LEVEL_W'(BLACK_PED);
  localparam logic [LEVEL_W-1:0] BLANK_L = LEVEL_W'(BLANK_PED);
  localparam logic [LEVEL_W-1:0] OVER_L  = LEVEL_W'(OVER_PED);
  localparam logic [LEVEL_W-1:0] RESET_L = LEVEL_W'(BLACK_PED + BLANK_PED);

  logic [DATA_W-1:0]  pixQ;
  logic [DATA_W-1:0]  effPix;
  logic [LEVEL_W-1:0] levelNext;

  always_ff @(negedge clk) begin
    if (rst) pixQ <= '0;
    else     pixQ <= pixIn;
  end

  always_comb begin
    if (strobes.forceZero)      effPix = '0;
    else if (strobes.forceFull) effPix = '1;
    else                        effPix = pixQ;
    levelNext = LEVEL_W'(effPix)
              + (strobes.addBlack ? BLACK_L : '0)
              + (strobes.addBlank ? BLANK_L : '0)
              + (strobes.addOver  ? OVER_L  : '0);
  end

  always_ff @(negedge clk) begin
    if (rst) levelOut <= RESET_L;
    else     levelOut <= levelNext;
  end

  // R6
  over_pedestal_chk: assert property (@(negedge clk) disable iff (rst)
    ($past(strobes.addOver) && !$past(rst)) |-> (levelOut >= BLACK_L + OVER_L));

  // R3
  blank_zero_chk: assert property (@(negedge clk) disable iff (rst)
    ($past(strobes.forceZero) && !$past(strobes.addBlank) && !$past(rst))
      |-> (levelOut == '0));
endmodule

// File: rtl/vdac_level_gen.sv
module vdac_level_gen
  import vdac_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BLACK_PED = 21,
  parameter int BLANK_PED = 111,
  parameter int OVER_PED  = 27,
  localparam int MAX_LEVEL = (1 << DATA_W) - 1 + BLACK_PED + BLANK_PED + OVER_PED,
  localparam int LEVEL_W   = $clog2(MAX_LEVEL + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  pixIn,
  input  logic               blankN,
  input  logic               syncN,
  input  logic               refWhiteN,
  input  logic               overBrtN,
  input  logic               straightN,
  output logic [LEVEL_W-1:0] levelOut
);
  levelStrobes_t strobes;

  vdac_ctrl ctrl_i (
    .clk(clk), .rst(rst), .blankN(blankN), .syncN(syncN),
    .refWhiteN(refWhiteN), .overBrtN(overBrtN), .straightN(straightN),
    .strobes(strobes)
  );

  vdac_datapath #(
    .DATA_W(DATA_W), .BLACK_PED(BLACK_PED), .BLANK_PED(BLANK_PED),
    .OVER_PED(OVER_PED), .LEVEL_W(LEVEL_W)
  ) dp_i (
    .clk(clk), .rst(rst), .pixIn(pixIn), .strobes(strobes), .levelOut(levelOut)
  );

  // Warm-up count so that two-deep history checks see post-reset inputs only
  logic [1:0] warmCnt;
  always_ff @(negedge clk) begin
    if (rst) warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end
  logic warm;
  assign warm = (warmCnt >= 2'd2);

  // R8
  reset_level_chk: assert property (@(negedge clk)
    $past(rst) |-> (levelOut == LEVEL_W'(BLACK_PED + BLANK_PED)));

  // R8
  level_range_chk: assert property (@(negedge clk) disable iff (rst)
    levelOut <= LEVEL_W'(MAX_LEVEL));

  // R5
  ref_white_chk: assert property (@(negedge clk) disable iff (rst)
    (warm && $past(blankN, 2) && !$past(refWhiteN, 2) && !$past(straightN, 2))
      |-> (levelOut == LEVEL_W'((1 << DATA_W) - 1)));

  // R7
  straight_pass_chk: assert property (@(negedge clk) disable iff (rst)
    (warm && !$past(straightN, 2) && $past(blankN, 2) && $past(refWhiteN, 2))
      |-> (levelOut == LEVEL_W'($past(pixIn, 2))));

  // R4
  sync_drop_chk: assert property (@(negedge clk) disable iff (rst)
    (warm && !$past(syncN, 2) && $past(straightN, 2) && $past(blankN, 2)
          && $past(refWhiteN, 2) && $past(overBrtN, 2))
      |-> (levelOut == LEVEL_W'($past(pixIn, 2)) + LEVEL_W'(BLACK_PED)));
endmodule

// File: tb/vdac_level_gen_tb.sv
module vdac_level_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pixIn = 8'd0;
  logic       blankN = 1'b1, syncN = 1'b1, refWhiteN = 1'b1, overBrtN = 1'b1, straightN = 1'b1;
  logic [8:0] levelOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vdac_level_gen dut_i (
    .clk(clk), .rst(rst), .pixIn(pixIn), .blankN(blankN), .syncN(syncN),
    .refWhiteN(refWhiteN), .overBrtN(overBrtN), .straightN(straightN),
    .levelOut(levelOut)
  );

  function automatic int expLevel(input int d, input bit bN, input bit sN,
                                  input bit wN, input bit oN, input bit stN);
    int lv;
    if (!bN)      lv = 0;
    else if (!wN) lv = 255;
    else          lv = d;
    if (stN) begin
      if (bN)        lv += 21;
      if (sN)        lv += 111;
      if (bN && !oN) lv += 27;
    end
    return lv;
  endfunction

  function automatic string reqOf(input bit bN, input bit sN,
                                  input bit wN, input bit oN, input bit stN);
    if (!stN) return "R7";
    if (!bN)  return "R3";
    if (!wN)  return "R5";
    if (!oN)  return "R6";
    if (!sN)  return "R4";
    return "R2";
  endfunction

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int d, input bit bN, input bit sN,
                       input bit wN, input bit oN, input bit stN);
    pixIn = 8'(d); blankN = bN; syncN = sN; refWhiteN = wN; overBrtN = oN; straightN = stN;
  endtask

  // Drive after a rising edge, sample one unit after the second following rising edge
  task automatic applyCheck(input int d, input bit [4:0] c);
    @(posedge clk); #1;
    drive(d, c[4], c[3], c[2], c[1], c[0]);
    @(posedge clk); @(posedge clk); #1;
    checkEq(reqOf(c[4], c[3], c[2], c[1], c[0]), int'(levelOut),
            expLevel(d, c[4], c[3], c[2], c[1], c[0]));
  endtask

  initial begin
    int pixSet[4] = '{0, 1, 128, 255};
    void'($urandom(32'd20240611));
    // R8: reset state
    repeat (3) @(posedge clk);
    #1; checkEq("R8", int'(levelOut), 132);
    rst = 1'b0;
    // R2 R3 R4 R5 R6 R7: every control combination with corner pixels
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 32; c++)
        applyCheck(pixSet[p], 5'(c));
    // R8: maximum code
    applyCheck(255, 5'b11101);
    // R1: back-to-back latency
    @(posedge clk); #1; drive(200, 1, 1, 1, 1, 1);
    @(posedge clk); #1; drive(10, 1, 1, 1, 1, 0);
    checkEq("R1", int'(levelOut), expLevel(255, 1, 1, 1, 0, 1));
    @(posedge clk); #1;
    checkEq("R1", int'(levelOut), 332);
    @(posedge clk); #1;
    checkEq("R1", int'(levelOut), 10);
    // Random mixes
    for (int i = 0; i < 300; i++) begin
      int d = int'($urandom_range(0, 255));
      bit [4:0] c = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 1) == 1) c = c | 5'b10001;
      applyCheck(d, c);
    end
    // R8: reset mid-stream returns to idle level
    @(posedge clk); #1; drive(77, 1, 0, 0, 0, 1); rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    checkEq("R8", int'(levelOut), 132);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule